// File: doc/BRIEF.md
# Time-of-Day Counter with Selectable Event Interrupt

This block keeps time of day as seconds, minutes and hours. A two-stage divider turns the core clock into a one-cycle seconds tick, and the tick steps the seconds register. A seconds wrap carries into minutes, and a minutes wrap carries into hours. The count can use plain binary or packed decimal digits (BCD, one digit per nibble). A control byte selects the encoding and can freeze the whole chain. It also shows whether the time registers are stable enough to sample, and it picks which time event sets a sticky interrupt flag.

Software uses a single-cycle synchronous register port. A write takes effect on the clock edge where `bus_wr` is high. A read is combinational on `bus_addr`. The register map is:

| Address | Register |
|---|---|
| 0 | control |
| 1 | seconds |
| 2 | minutes |
| 3 | hours |
| 4 | event flag, bit 0 |

The usual sequence has four steps. Set the freeze bit, load the time in the chosen encoding, pick the event, then clear the freeze bit.

Top module: `rtc_evt_clock`

## Requirements
- R1: After reset the control register reads 0x70, the seconds, minutes and hours registers read 0, the event flag reads 0, `irq` is low, and an unmapped address reads 0.
- R2: While control bit 6 (freeze) is 1, the divider and the time registers do not move. While it is 0, the seconds register steps once every PRE0_DIV*PRE1_DIV clocks.
- R3: In binary mode (control bit 7 = 0), seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0. Each wrap carries one step into the next register.
- R4: In BCD mode (control bit 7 = 1), each nibble holds one decimal digit. The low digit passes 9 into the next tens value (0x09 to 0x10). The limits are 0x59, 0x59 and 0x23, and each wraps to 0x00.
- R5: Control bit 4 reads 0 during the last READY_GUARD clocks before each seconds update and 1 at all other times. It always reads 1 while frozen.
- R6: Control bits 1:0 select the event: 00 for a minutes change, 01 for an hours change, 10 for hours wrapping to 00:00, and 11 for hours stepping into 12:00. Events that are not selected leave the flag alone.
- R7: The selected event sets the event flag (address 4, bit 0), and `irq` follows the flag. Writing 1 to bit 0 clears the flag. If a clear and an event arrive in the same cycle, the event wins.
- R8: Control bit 5 always reads 1 and bits 3:2 always read 0. Writes to bits 5, 4, 3 and 2 have no effect.
- R9: A write to a time register is accepted only while freeze is 1. While the clock runs, such a write leaves the register unchanged.
- R10: Changing control bit 7 leaves the stored time values unchanged. No code conversion takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that feeds the divider |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Copy of the sticky event flag |

## Verification
All time, control and flag state sits in flops that update on the edge where a write or a seconds tick is sampled. The results are due as follows:
- Read data shows the new value in the same half cycle that follows that edge.
- The ready bit changes with the divider position and needs no extra register.
- `irq` rises at the edge that carries the selected wrap.

The bench drives inputs and samples outputs one nanosecond after the falling edge. It keeps a cycle-by-cycle reference model that advances on the same rising edges, so every comparison is made in the cycle where the result is due. For directed timing cases, such as the one-tick window and a clear that collides with an event, the bench waits on the model's divider position before it acts.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_HR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        EV_MINUTE   = 2'b00,
        EV_HOUR     = 2'b01,
        EV_MIDNIGHT = 2'b10,
        EV_NOON     = 2'b11
    } ev_sel_e;

    typedef struct packed {
        logic       bcd;
        logic       hold;
        ev_sel_e    evsel;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic       flag;
    } rtc_state_t;

    function automatic int unit_limit(int idx);
        return (idx == NUM_UNITS - 1) ? 23 : 59;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int DIV = 4,
    parameter int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] count,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (en) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/rtc_time_unit.sv
module rtc_time_unit #(
    parameter int LIMIT = 59
) (
    input  logic [7:0] cur,
    input  logic       bcd,
    input  logic       inc,
    output logic [7:0] nxt,
    output logic       wrap
);

    localparam logic [3:0] LIM_HI  = 4'(LIMIT / 10);
    localparam logic [3:0] LIM_LO  = 4'(LIMIT % 10);
    localparam logic [7:0] LIM_BIN = 8'(LIMIT);

    logic       at_lim;
    logic [7:0] stepped;

    always_comb begin
        if (bcd) begin
            at_lim = (cur[7:4] > LIM_HI) ||
                     ((cur[7:4] == LIM_HI) && (cur[3:0] >= LIM_LO));
        end else begin
            at_lim = (cur >= LIM_BIN);
        end

        if (at_lim) begin
            stepped = 8'h00;
        end else if (bcd && (cur[3:0] >= 4'd9)) begin
            stepped = {cur[7:4] + 4'd1, 4'h0};
        end else begin
            stepped = cur + 8'd1;
        end

        nxt  = inc ? stepped : cur;
        wrap = inc && at_lim;
    end

endmodule

// File: rtl/rtc_evt_clock.sv
module rtc_evt_clock
    import rtc_evt_pkg::*;
#(
    parameter int PRE0_DIV    = 4,
    parameter int PRE1_DIV    = 4,
    parameter int READY_GUARD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);

    localparam int TICK_PERIOD = PRE0_DIV * PRE1_DIV;
    localparam int C0W         = (PRE0_DIV > 1) ? $clog2(PRE0_DIV) : 1;
    localparam int C1W         = (PRE1_DIV > 1) ? $clog2(PRE1_DIV) : 1;
    localparam int POS_W       = $clog2(TICK_PERIOD) + 1;
    localparam logic [POS_W-1:0] READY_START = POS_W'(TICK_PERIOD - READY_GUARD);

    rtc_state_t state_d, state_q;

    logic           run;
    logic [C0W-1:0] c0;
    logic [C1W-1:0] c1;
    logic           w0;
    logic           sec_tick;
    logic [POS_W-1:0] pos;
    logic           ready;
    logic           event_hit;

    logic [7:0] cur [NUM_UNITS];
    logic [7:0] nxt [NUM_UNITS];
    logic       inc [NUM_UNITS];
    logic       wrp [NUM_UNITS];

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^bus_wdata[5:2];

    assign run = !state_q.hold;

    rtc_divider #(.DIV(PRE0_DIV), .CW(C0W)) u_div0 (
        .clk(clk), .rst_n(rst_n), .en(run), .count(c0), .wrap(w0)
    );

    rtc_divider #(.DIV(PRE1_DIV), .CW(C1W)) u_div1 (
        .clk(clk), .rst_n(rst_n), .en(w0), .count(c1), .wrap(sec_tick)
    );

    assign pos   = POS_W'(c1) * POS_W'(PRE0_DIV) + POS_W'(c0);
    assign ready = state_q.hold || (pos < READY_START);

    assign cur[0] = state_q.sec;
    assign cur[1] = state_q.min;
    assign cur[2] = state_q.hr;

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        if (i == 0) begin : g_first
            assign inc[i] = sec_tick;
        end else begin : g_chain
            assign inc[i] = wrp[i-1];
        end
        rtc_time_unit #(.LIMIT(unit_limit(i))) u_unit (
            .cur(cur[i]), .bcd(state_q.bcd), .inc(inc[i]),
            .nxt(nxt[i]), .wrap(wrp[i])
        );
    end

    always_comb begin
        logic [7:0] noon_code;
        noon_code = state_q.bcd ? 8'h12 : 8'd12;
        case (state_q.evsel)
            EV_MINUTE:   event_hit = wrp[0];
            EV_HOUR:     event_hit = wrp[1];
            EV_MIDNIGHT: event_hit = wrp[2];
            EV_NOON:     event_hit = inc[2] && (nxt[2] == noon_code);
            default:     event_hit = 1'b0;
        endcase
    end

    always_comb begin
        state_d     = state_q;
        state_d.sec = nxt[0];
        state_d.min = nxt[1];
        state_d.hr  = nxt[2];
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    state_d.bcd   = bus_wdata[7];
                    state_d.hold  = bus_wdata[6];
                    state_d.evsel = ev_sel_e'(bus_wdata[1:0]);
                end
                A_SEC:  if (state_q.hold) state_d.sec = bus_wdata;
                A_MIN:  if (state_q.hold) state_d.min = bus_wdata;
                A_HR:   if (state_q.hold) state_d.hr  = bus_wdata;
                A_FLAG: if (bus_wdata[0]) state_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (event_hit) state_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.hold  <= 1'b1;
            state_q.evsel <= EV_MINUTE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {state_q.bcd, state_q.hold, 1'b1, ready, 2'b00, state_q.evsel};
            A_SEC:   bus_rdata = state_q.sec;
            A_MIN:   bus_rdata = state_q.min;
            A_HR:    bus_rdata = state_q.hr;
            A_FLAG:  bus_rdata = {7'b0, state_q.flag};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq = state_q.flag;

endmodule

// File: rtl/rtc_evt_clock_chk.sv
module rtc_evt_clock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold,
    input logic       tick,
    input logic       ready,
    input logic       time_wr,
    input logic       sec_wr,
    input logic       clr,
    input logic [7:0] sec,
    input logic [7:0] min,
    input logic [7:0] hr,
    input logic       flag,
    input logic       evt
);

    assert_held_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !tick);

    assert_held_time_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !time_wr) |=> ($stable(sec) && $stable(min) && $stable(hr)));

    assert_ready_low_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !ready);

    assert_event_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_run_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !tick && sec_wr) |=> $stable(sec));

endmodule

bind rtc_evt_clock rtc_evt_clock_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (state_q.hold),
    .tick    (sec_tick),
    .ready   (ready),
    .time_wr (bus_wr && (bus_addr == rtc_evt_pkg::A_SEC || bus_addr == rtc_evt_pkg::A_MIN ||
                         bus_addr == rtc_evt_pkg::A_HR)),
    .sec_wr  (bus_wr && (bus_addr == rtc_evt_pkg::A_SEC)),
    .clr     (bus_wr && (bus_addr == rtc_evt_pkg::A_FLAG) && bus_wdata[0]),
    .sec     (state_q.sec),
    .min     (state_q.min),
    .hr      (state_q.hr),
    .flag    (state_q.flag),
    .evt     (event_hit)
);

// File: tb/rtc_evt_clock_tb.sv
`timescale 1ns/1ps
module rtc_evt_clock_tb;

    localparam int P0    = 4;
    localparam int P1    = 4;
    localparam int GUARD = 3;
    localparam int TOT   = P0 * P1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_evt_clock #(.PRE0_DIV(P0), .PRE1_DIV(P1), .READY_GUARD(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model
    int         m_pre;
    logic       m_bcd, m_hold, m_flag;
    logic [1:0] m_evsel;
    logic [7:0] m_sec, m_min, m_hr;

    function automatic int dec(logic [7:0] v, logic b);
        return b ? (int'(v[7:4]) * 10 + int'(v[3:0])) : int'(v);
    endfunction

    function automatic logic [7:0] enc(int n, logic b);
        return b ? {4'(n / 10), 4'(n % 10)} : 8'(n);
    endfunction

    always @(posedge clk) begin : model
        logic tk, w0, w1, w2, ev;
        logic [7:0] ns, nm, nh;
        if (!rst_n) begin
            m_pre <= 0; m_bcd <= 0; m_hold <= 1; m_flag <= 0;
            m_evsel <= 2'b00; m_sec <= 0; m_min <= 0; m_hr <= 0;
        end else begin
            tk = !m_hold && (m_pre == TOT - 1);
            if (!m_hold) m_pre <= tk ? 0 : m_pre + 1;
            ns = m_sec; nm = m_min; nh = m_hr;
            w0 = 0; w1 = 0; w2 = 0;
            if (tk) begin
                w0 = dec(m_sec, m_bcd) >= 59;
                ns = w0 ? 8'h00 : enc(dec(m_sec, m_bcd) + 1, m_bcd);
                if (w0) begin
                    w1 = dec(m_min, m_bcd) >= 59;
                    nm = w1 ? 8'h00 : enc(dec(m_min, m_bcd) + 1, m_bcd);
                    if (w1) begin
                        w2 = dec(m_hr, m_bcd) >= 23;
                        nh = w2 ? 8'h00 : enc(dec(m_hr, m_bcd) + 1, m_bcd);
                    end
                end
            end
            case (m_evsel)
                2'b00:   ev = w0;
                2'b01:   ev = w1;
                2'b10:   ev = w2;
                default: ev = w1 && (dec(nh, m_bcd) == 12);
            endcase
            m_sec <= ns; m_min <= nm; m_hr <= nh;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        m_bcd <= bus_wdata[7]; m_hold <= bus_wdata[6]; m_evsel <= bus_wdata[1:0];
                    end
                    3'd1: if (m_hold) m_sec <= bus_wdata;
                    3'd2: if (m_hold) m_min <= bus_wdata;
                    3'd3: if (m_hold) m_hr  <= bus_wdata;
                    3'd4: if (bus_wdata[0]) m_flag <= 1'b0;
                    default: ;
                endcase
            end
            if (ev) m_flag <= 1'b1;
        end
    end

    function automatic logic [7:0] model_rd(logic [2:0] a);
        logic rdy;
        rdy = m_hold || (m_pre < TOT - GUARD);
        case (a)
            3'd0:    return {m_bcd, m_hold, 1'b1, rdy, 2'b00, m_evsel};
            3'd1:    return m_sec;
            3'd2:    return m_min;
            3'd3:    return m_hr;
            3'd4:    return {7'b0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0:    return "R8";
            3'd1:    return "R2";
            3'd2:    return "R3";
            3'd3:    return "R3";
            3'd4:    return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // one clock: drive now (just after negedge), compare, advance to next negedge
    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d);
        bus_wr = we; bus_addr = a; bus_wdata = d;
        #1;
        check(tag_of(a), bus_rdata, model_rd(a));
        check("R7", {7'b0, irq}, {7'b0, m_flag});
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'($urandom_range(0, 5)), 8'h00);
    endtask

    task automatic idle_until(input int p);
        while (m_pre != p) cyc(1'b0, 3'($urandom_range(0, 5)), 8'h00);
    endtask

    task automatic load(input logic [7:0] ctrl_held, input logic [7:0] h,
                        input logic [7:0] m, input logic [7:0] s);
        cyc(1'b1, 3'd0, ctrl_held);
        cyc(1'b1, 3'd1, s);
        cyc(1'b1, 3'd2, m);
        cyc(1'b1, 3'd3, h);
        cyc(1'b1, 3'd4, 8'h01);
    endtask

    // run about 2.5 seconds from a held load, then freeze again
    task automatic run_freeze(input logic [7:0] ctrl_held);
        cyc(1'b1, 3'd0, ctrl_held & 8'hBF);
        idle(40);
        cyc(1'b1, 3'd0, ctrl_held);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] exp_v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd0, 8'h70, "R1");
        rd(3'd1, 8'h00, "R1");
        rd(3'd3, 8'h00, "R1");
        rd(3'd4, 8'h00, "R1");
        rd(3'd6, 8'h00, "R1");
        check("R1", {7'b0, irq}, 8'h00);

        // R2 frozen after reset
        idle(3 * TOT);
        rd(3'd1, 8'h00, "R2");

        // R8 reserved bits
        cyc(1'b1, 3'd0, 8'h7F);
        rd(3'd0, 8'h73, "R8");
        cyc(1'b1, 3'd0, 8'h40);
        rd(3'd0, 8'h70, "R8");

        // R6 noon event, binary
        load(8'h43, 8'd11, 8'd59, 8'd58);
        run_freeze(8'h43);
        rd(3'd3, 8'd12, "R3");
        rd(3'd2, 8'd0, "R3");
        rd(3'd4, 8'h01, "R6");

        // R6 midnight event
        load(8'h42, 8'd23, 8'd59, 8'd58);
        run_freeze(8'h42);
        rd(3'd3, 8'd0, "R3");
        rd(3'd4, 8'h01, "R6");

        // R6 noon not hit by midnight
        load(8'h43, 8'd23, 8'd59, 8'd58);
        run_freeze(8'h43);
        rd(3'd4, 8'h00, "R6");

        // R6 hour event
        load(8'h41, 8'd5, 8'd59, 8'd58);
        run_freeze(8'h41);
        rd(3'd3, 8'd6, "R6");
        rd(3'd4, 8'h01, "R6");

        // R6 hour selected, minute-only change
        load(8'h41, 8'd0, 8'd10, 8'd58);
        run_freeze(8'h41);
        rd(3'd2, 8'd11, "R6");
        rd(3'd4, 8'h00, "R6");

        // R6 minute event
        load(8'h40, 8'd0, 8'd10, 8'd58);
        run_freeze(8'h40);
        rd(3'd4, 8'h01, "R6");

        // R4 BCD midnight
        load(8'hC2, 8'h23, 8'h59, 8'h58);
        run_freeze(8'hC2);
        rd(3'd3, 8'h00, "R4");
        rd(3'd2, 8'h00, "R4");
        rd(3'd4, 8'h01, "R4");

        // R4 digit carry over exactly one tick, R2 tick period
        cyc(1'b1, 3'd1, 8'h09);
        cyc(1'b1, 3'd0, 8'h82);
        idle(TOT - 1);
        cyc(1'b1, 3'd0, 8'hC2);
        rd(3'd1, 8'h10, "R4");

        // R10 no conversion on encoding switch
        cyc(1'b1, 3'd0, 8'h42);
        cyc(1'b1, 3'd1, 8'd45);
        cyc(1'b1, 3'd0, 8'hC2);
        rd(3'd1, 8'd45, "R10");
        cyc(1'b1, 3'd0, 8'h42);

        // R5 ready window
        cyc(1'b1, 3'd0, 8'h00);
        idle_until(TOT - GUARD);
        bus_addr = 3'd0; #1;
        check("R5", {7'b0, bus_rdata[4]}, 8'h00);
        @(posedge clk); @(negedge clk);
        idle_until(0);
        bus_addr = 3'd0; #1;
        check("R5", {7'b0, bus_rdata[4]}, 8'h01);
        @(posedge clk); @(negedge clk);

        // R7 clear collides with event: event wins
        cyc(1'b1, 3'd0, 8'h40);
        cyc(1'b1, 3'd1, 8'd59);
        cyc(1'b1, 3'd4, 8'h01);
        cyc(1'b1, 3'd0, 8'h00);
        idle_until(TOT - 1);
        cyc(1'b1, 3'd4, 8'h01);
        rd(3'd4, 8'h01, "R7");
        cyc(1'b1, 3'd4, 8'h01);
        rd(3'd4, 8'h00, "R7");

        // R9 write while running ignored
        exp_v = m_min;
        cyc(1'b1, 3'd2, exp_v + 8'd7);
        rd(3'd2, exp_v, "R9");

        // random phase, binary then BCD
        for (int phase = 0; phase < 2; phase++) begin
            logic b;
            b = phase[0];
            cyc(1'b1, 3'd0, {b, 7'b1000000});
            cyc(1'b1, 3'd1, enc(58, b));
            cyc(1'b1, 3'd2, enc(59, b));
            cyc(1'b1, 3'd3, enc(23, b));
            for (int i = 0; i < 3000; i++) begin
                int r;
                int u;
                r = $urandom_range(0, 99);
                if (r < 3) begin
                    cyc(1'b1, 3'd0, {b, ~m_hold, 4'($urandom), 2'($urandom)});
                end else if (r < 12) begin
                    u = $urandom_range(1, 3);
                    cyc(1'b1, 3'(u), enc((u == 3) ? $urandom_range(22, 23) : $urandom_range(57, 59), b));
                end else if (r < 16) begin
                    cyc(1'b1, 3'd4, 8'($urandom));
                end else begin
                    cyc(1'b0, 3'($urandom_range(0, 7)), 8'($urandom));
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule